// File: doc/BRIEF.md
# Diagnostic Event Counters with Coherent Snapshot

This block keeps a bank of saturating 16-bit diagnostic counters, one for each of five event sources: level-0, level-1 and level-2 trigger pulses, data-strobe words (one pulse per 40-bit word sent by the readout chips), and sample clocks. Each source delivers a single-cycle pulse. The live counters run continuously and cannot be read directly.

A latch command copies every live counter into its shadow register in the same clock cycle. The snapshot is therefore coherent across the bank. When the latch is sent to many front-end cards at once, their snapshots can be compared one to one. A clear command zeroes the live counters and leaves the shadow registers alone. Software reads the shadow values through a select-and-data read port. The bus decoding around that port, and the logic that produces the event pulses, live outside this block.

The reset input is asynchronous and active-low. Its assertion takes effect at once; its release is synchronised to the clock over two stages.

Top module: `diag_event_counters`

## Requirements
- R1: While reset is asserted, and after it is released, every live counter and every shadow register holds 0x0000, so every read returns 0x0000 until the first latch. The counters start to respond in the third clock edge after rst_n rises.
- R2: Each event input bit drives its own counter. Bit 0 is level-0 trigger, bit 1 level-1 trigger, bit 2 level-2 trigger, bit 3 data strobe and bit 4 sample clock. A counter increments by exactly one for each cycle in which its bit is 1.
- R3: Read data depends only on the shadow registers. Events alone never change the value read at any select.
- R4: A latch pulse copies all five live counters into their shadow registers at the same clock edge. An event in the latch cycle is not part of the snapshot; it appears in the next latch.
- R5: A clear pulse sets all live counters to zero. If an event arrives in the same cycle as a clear, the clear wins and the counter is zero afterwards.
- R6: When latch and clear arrive in the same cycle, the shadow registers capture the values from before the clear.
- R7: A clear does not change any shadow register. Only a later latch does.
- R8: A counter that has reached 0xFFFF stays at 0xFFFF when more events arrive. It does not wrap.
- R9: Read select values 0 to 4 return the shadow register of the event with the same bit index. Select values 5 to 7 return 0x0000.
- R10: The counters are independent. Any combination of event bits in one cycle increments exactly the counters whose bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously |
| evt_i | input | 5 | Single-cycle event pulses, one bit per counter (bit order as in R2) |
| latch_i | input | 1 | Snapshot command strobe |
| clear_i | input | 1 | Live counter clear strobe |
| rd_sel_i | input | 3 | Read select, index of the shadow register to read |
| rd_data_o | output | 16 | Shadow register value selected by rd_sel_i |

## Verification
Saturation is the hardest case to reach from the ports, because a counter has to see 65535 events before it saturates. The bench pulses all five event lines together on every cycle for slightly more than that count, latches, and checks that every read returns 0xFFFF. It then adds further events, latches again, and checks that the values still read 0xFFFF. All 32 combinations of the event bits are also swept exhaustively. The same-cycle corners (latch with an event, latch with a clear, clear with an event) are each driven on a single chosen cycle against a bench model that tracks the counters cycle by cycle.

// File: rtl/dec_pkg.sv
package dec_pkg;
  parameter int unsigned DEC_CNT_W   = 16;
  parameter int unsigned DEC_NUM_EVT = 5;

  // Bit index of each event source on the event input vector
  typedef enum logic [2:0] {
    EV_TRIG0  = 3'd0,
    EV_TRIG1  = 3'd1,
    EV_TRIG2  = 3'd2,
    EV_STROBE = 3'd3,
    EV_SMPCLK = 3'd4
  } dec_evt_e;
endpackage

// File: rtl/dec_rst_sync.sv
module dec_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dec_live_cnt.sv
module dec_live_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Clear has priority over an event; a saturated counter holds its value
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr_i) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (evt_i && (cnt_q != CNT_MAX)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dec_shadow_bank.sv
module dec_shadow_bank #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_EVT = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           latch_i,
  input  logic [NUM_EVT-1:0][CNT_W-1:0] live_i,
  output logic [NUM_EVT-1:0][CNT_W-1:0] shadow_o
);
  logic [NUM_EVT-1:0][CNT_W-1:0] shadow_q;
  logic [NUM_EVT-1:0][CNT_W-1:0] shadow_d;

  always_comb begin
    shadow_d = live_i;
  end

  // One enable for the whole bank keeps the snapshot coherent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shadow_q <= '0;
    else if (latch_i) shadow_q <= shadow_d;
  end

  assign shadow_o = shadow_q;
endmodule

// File: rtl/dec_read_mux.sv
module dec_read_mux #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_EVT = 5,
  parameter int unsigned SEL_W   = 3
) (
  input  logic [NUM_EVT-1:0][CNT_W-1:0] shadow_i,
  input  logic [SEL_W-1:0]              sel_i,
  output logic [CNT_W-1:0]              data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (sel_i == SEL_W'(i)) data_o = shadow_i[i];
    end
  end
endmodule

// File: rtl/diag_event_counters.sv
module diag_event_counters
  import dec_pkg::*;
#(
  parameter int unsigned CNT_W   = DEC_CNT_W,
  parameter int unsigned NUM_EVT = DEC_NUM_EVT,
  localparam int unsigned SEL_W  = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               latch_i,
  input  logic               clear_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [CNT_W-1:0]   rd_data_o
);
  logic                          rst_sync_n;
  logic [NUM_EVT-1:0][CNT_W-1:0] live_q;
  logic [NUM_EVT-1:0][CNT_W-1:0] shadow_q;

  dec_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cnt
    dec_live_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .evt_i (evt_i[g]),
      .clr_i (clear_i),
      .cnt_o (live_q[g])
    );
  end

  dec_shadow_bank #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .latch_i  (latch_i),
    .live_i   (live_q),
    .shadow_o (shadow_q)
  );

  dec_read_mux #(.CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_rd (
    .shadow_i (shadow_q),
    .sel_i    (rd_sel_i),
    .data_o   (rd_data_o)
  );
endmodule

// File: rtl/diag_event_counters_chk.sv
module diag_event_counters_chk #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_EVT = 5,
  parameter int unsigned SEL_W   = 3
) (
  input logic                          clk,
  input logic                          rst_sync_n,
  input logic [NUM_EVT-1:0]            evt_i,
  input logic                          latch_i,
  input logic                          clear_i,
  input logic [SEL_W-1:0]              rd_sel_i,
  input logic [CNT_W-1:0]              rd_data_o,
  input logic [NUM_EVT-1:0][CNT_W-1:0] live_q,
  input logic [NUM_EVT-1:0][CNT_W-1:0] shadow_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_chk
    // R2
    incr_by_one_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (evt_i[g] && !clear_i && live_q[g] != CNT_MAX) |=> live_q[g] == $past(live_q[g]) + 1'b1);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!evt_i[g] && !clear_i) |=> $stable(live_q[g]));
    // R4
    latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      latch_i |=> shadow_q[g] == $past(live_q[g]));
    // R5
    clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      clear_i |=> live_q[g] == '0);
    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (live_q[g] == CNT_MAX && !clear_i) |=> live_q[g] == CNT_MAX);
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !latch_i |=> $stable(shadow_q));
  // R3
  read_stable_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!latch_i && $stable(rd_sel_i)) |=> $stable(rd_data_o));
  // R9
  sel_range_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (int'(rd_sel_i) >= NUM_EVT) |-> rd_data_o == '0);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    !rst_sync_n |-> (live_q == '0 && shadow_q == '0));
endmodule

bind diag_event_counters diag_event_counters_chk #(
  .CNT_W(CNT_W), .NUM_EVT(NUM_EVT), .SEL_W(SEL_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .evt_i      (evt_i),
  .latch_i    (latch_i),
  .clear_i    (clear_i),
  .rd_sel_i   (rd_sel_i),
  .rd_data_o  (rd_data_o),
  .live_q     (live_q),
  .shadow_q   (shadow_q)
);

// File: tb/diag_event_counters_tb_top.sv
`timescale 1ns/100ps
module diag_event_counters_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  evt = '0;
  logic        latch = 1'b0;
  logic        clear = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] m_live [5];
  logic [15:0] m_shad [5];

  always #2.5 clk = ~clk;

  diag_event_counters dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .latch_i(latch),
    .clear_i(clear), .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  task automatic cmp(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, rd_sel, act, exp);
    end
  endtask

  // One clock cycle of stimulus; model follows the requirements
  task automatic step(input logic [4:0] e, input logic l, input logic c);
    @(negedge clk);
    evt = e; latch = l; clear = c;
    @(posedge clk);
    if (l) for (int i = 0; i < 5; i++) m_shad[i] = m_live[i];
    for (int i = 0; i < 5; i++) begin
      if (c) m_live[i] = '0;
      else if (e[i] && m_live[i] != 16'hFFFF) m_live[i] = m_live[i] + 16'd1;
    end
    #0.5;
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 5; i++) begin
      rd_sel = 3'(i);
      #0.2;
      cmp(tag, rd_data, m_shad[i]);
    end
    rd_sel = '0;
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin m_live[i] = '0; m_shad[i] = '0; end
    repeat (3) @(posedge clk);
    #0.5;
    check_all("R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    repeat (3) step(5'b0, 1'b0, 1'b0);
    check_all("R1 after reset");

    // R2: each bit counts its own source, distinct counts per bit
    for (int b = 0; b < 5; b++)
      for (int k = 0; k < 3 * (b + 1); k++) step(5'(1 << b), 1'b0, 1'b0);
    check_all("R3 before latch");
    step(5'b0, 1'b1, 1'b0);
    check_all("R2 per-bit counts");

    // R10: exhaustive sweep of all event bit combinations
    for (int p = 0; p < 32; p++) step(5'(p), 1'b0, 1'b0);
    check_all("R3 no latch after sweep");
    step(5'b0, 1'b1, 1'b0);
    check_all("R10 exhaustive sweep");

    // R4: event in latch cycle excluded from snapshot
    step(5'b10101, 1'b1, 1'b0);
    check_all("R4 latch with event");
    step(5'b0, 1'b1, 1'b0);
    check_all("R4 event seen next latch");

    // R7: clear leaves shadows untouched
    step(5'b0, 1'b0, 1'b1);
    check_all("R7 clear keeps shadow");
    step(5'b11111, 1'b0, 1'b0);
    step(5'b00011, 1'b0, 1'b0);
    // R6: latch and clear together capture pre-clear values
    step(5'b11111, 1'b1, 1'b1);
    check_all("R6 latch with clear");
    // R5: clear beats event in same cycle
    step(5'b11111, 1'b0, 1'b1);
    step(5'b0, 1'b1, 1'b0);
    check_all("R5 clear wins");

    // R8: saturation
    for (int k = 0; k < 65540; k++) step(5'b11111, 1'b0, 1'b0);
    step(5'b0, 1'b1, 1'b0);
    check_all("R8 saturated");
    for (int i = 0; i < 5; i++) cmp("R8 model max", m_shad[i], 16'hFFFF);
    step(5'b11111, 1'b0, 1'b0);
    step(5'b11111, 1'b1, 1'b0);
    check_all("R8 holds max");

    // R9: out-of-range selects read zero
    for (int s = 5; s < 8; s++) begin
      rd_sel = 3'(s);
      #0.2;
      cmp("R9 out of range", rd_data, 16'h0000);
    end
    rd_sel = '0;

    step(5'b0, 1'b0, 1'b1);
    step(5'b0, 1'b1, 1'b0);
    check_all("R5 clear after saturation");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule